// File: doc/BRIEF.md
# DMA Interrupt Control and Status Register

This block holds the single 32-bit interrupt control and status word of a seven-channel DMA controller. Software writes the word to set up interrupt behaviour. The transfer engines report each finished transfer with a one-cycle pulse on a per-channel line. The block turns these into one interrupt request for the system interrupt controller.

The word has four kinds of bits:

- **Completion flags (bits 30:24):** latch a finished transfer when that channel is enabled. Software clears a flag by writing a one to it.
- **Control fields (bits 23:0):** take whatever software writes. These include a force bit (15), per-channel enables (22:16) and a master enable (23).
- **Aggregate bit (bit 31):** read-only. It shows the live combined interrupt level. That level is the force bit, or the master enable together with any set flag.

The request output fires only when the aggregate level rises from 0 to 1. While the level stays high, no further request is sent. A new request needs the level to drop and rise again.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset, the read value is all zeros and the interrupt request is low.
- R2: Bit 31 cannot be written. A write that sets bit 31 and leaves bits 15 and 23 at zero with no flags pending reads back bit 31 = 0.
- R3: Writing 1 to a bit in 30:24 clears that flag. Writing 0 to it leaves the flag unchanged.
- R4: Bits 23:0 hold exactly the last written value: force at bit 15, channel enables at 22:16 (channel n at bit 16+n), master enable at bit 23.
- R5: A completion pulse on channel n sets flag bit 24+n on the next clock edge, but only if enable bit 16+n is 1 before that edge. Otherwise the flag is unaffected.
- R6: If a completion pulse and a write-one-to-clear hit the same flag in one cycle, the flag ends up set.
- R7: Bit 31 reads force OR (master enable AND any flag in 30:24), computed from the register contents after the same clock edge.
- R8: The interrupt request is a one-cycle pulse. It is high exactly in the cycle in which bit 31 first reads 1 after reading 0, and low otherwise.
- R9: Bits 14:0 never affect bit 31 or the interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| done_i | input | 7 | Per-channel transfer-completion pulses |
| rd_data | output | 32 | Full register contents including bit 31 |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
A wrong flag or enable would show up on rd_data the cycle after the faulty write or completion pulse, since every field is read back directly. A stale or wrongly computed aggregate level would first show in bit 31. It would then show on irq_o: either a pulse is missing when the level rises, or an extra pulse appears while the level stays high. Both are visible within one cycle of the triggering event. The random run compares the full word and the request line on every cycle against a bench model. This includes cycles where set and clear collide on the same flag.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
    localparam int CH_COUNT = 7;
    localparam int WORD_W   = 32;

    typedef struct packed {
        logic lvl;
        logic pulse;
    } edge_state_t;
endpackage

// File: rtl/dma_irq_flags.sv
module dma_irq_flags #(
    parameter int NUM_CH = dma_irq_pkg::CH_COUNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] clr_mask,
    input  logic [NUM_CH-1:0] done,
    input  logic [NUM_CH-1:0] en_q,
    output logic [NUM_CH-1:0] flags_d,
    output logic [NUM_CH-1:0] flags_q
);
    logic [NUM_CH-1:0] set_hit;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_comb begin
            set_hit[c] = done[c] & en_q[c];
            flags_d[c] = set_hit[c] | (flags_q[c] & ~clr_mask[c]);
        end

        // R5: enabled completion sets the flag
        p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (done[c] && en_q[c]) |=> flags_q[c]);
        // R5: disabled channel cannot raise a clear flag
        p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_q[c] && !flags_q[c]) |=> !flags_q[c]);
        // R3: clear without set empties the flag
        p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_mask[c] && !done[c]) |=> !flags_q[c]);
        // R3: no clear keeps a set flag
        p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[c] && !clr_mask[c]) |=> flags_q[c]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end
endmodule

// File: rtl/dma_irq_edge.sv
module dma_irq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_d,
    output logic lvl_q,
    output logic pulse_q
);
    import dma_irq_pkg::*;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d.lvl   = lvl_d;
        st_d.pulse = lvl_d & ~st_q.lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_q   = st_q.lvl;
    assign pulse_q = st_q.pulse;

    // R8: a pulse only accompanies a fresh rise of the level
    p_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> (lvl_q && !$past(lvl_q)));
    // R8: pulse lasts one cycle
    p_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);
    // R8: every rise is reported
    p_report_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_d && !lvl_q) |=> pulse_q);
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl #(
    parameter int NUM_CH = dma_irq_pkg::CH_COUNT,
    parameter int WORD_W = dma_irq_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [NUM_CH-1:0] done_i,
    output logic [WORD_W-1:0] rd_data,
    output logic              irq_o
);
    localparam int SIG_BIT   = WORD_W - 1;
    localparam int FLAG_LSB  = SIG_BIT - NUM_CH;
    localparam int MASTER    = FLAG_LSB - 1;
    localparam int EN_LSB    = MASTER - NUM_CH;
    localparam int FORCE     = EN_LSB - 1;
    localparam int CTRL_W    = FLAG_LSB;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
    } ctrl_state_t;

    ctrl_state_t       cs_d, cs_q;
    logic [NUM_CH-1:0] clr_mask;
    logic [NUM_CH-1:0] flags_d, flags_q;
    logic              sig_d, sig_q;

    always_comb begin
        cs_d     = cs_q;
        clr_mask = '0;
        if (wr_en) begin
            cs_d.ctrl = wr_data[CTRL_W-1:0];
            clr_mask  = wr_data[FLAG_LSB +: NUM_CH];
        end
        sig_d = cs_d.ctrl[FORCE] | (cs_d.ctrl[MASTER] & (|flags_d));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    dma_irq_flags #(.NUM_CH(NUM_CH)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_mask(clr_mask),
        .done    (done_i),
        .en_q    (cs_q.ctrl[EN_LSB +: NUM_CH]),
        .flags_d (flags_d),
        .flags_q (flags_q)
    );

    dma_irq_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_d  (sig_d),
        .lvl_q  (sig_q),
        .pulse_q(irq_o)
    );

    assign rd_data = {sig_q, flags_q, cs_q.ctrl};

    // R7: stored aggregate matches the stored fields
    p_agg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[SIG_BIT] == (rd_data[FORCE] |
                             (rd_data[MASTER] & (|rd_data[FLAG_LSB +: NUM_CH]))));
    // R4: plain fields take the written value
    p_plain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[CTRL_W-1:0] == $past(wr_data[CTRL_W-1:0]));
    // R4: plain fields hold without a write
    p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data[CTRL_W-1:0]));
endmodule

// File: tb/dma_irq_ctrl_bench.sv
module dma_irq_ctrl_bench;
    localparam int PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [31:0] wr_data = '0;
    logic [6:0]  done_i = '0;
    logic [31:0] rd_data;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] model = '0;
    logic        model_irq = 0;

    always #(PERIOD/2) clk = ~clk;

    dma_irq_ctrl u_dma_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .done_i(done_i), .rd_data(rd_data), .irq_o(irq_o)
    );

    function automatic logic [32:0] next_of(logic [31:0] m, logic we,
                                            logic [31:0] wd, logic [6:0] dn);
        logic [6:0]  nf;
        logic [23:0] low;
        logic        s;
        nf  = (dn & m[22:16]) | (m[30:24] & ~(we ? wd[30:24] : 7'h0));
        low = we ? wd[23:0] : m[23:0];
        s   = low[15] | (low[23] & (|nf));
        return {s & ~m[31], s, nf, low};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic cyc(string req, logic we, logic [31:0] wd, logic [6:0] dn);
        logic [32:0] n;
        wr_en = we; wr_data = wd; done_i = dn;
        n = next_of(model, we, wd, dn);
        @(posedge clk);
        @(negedge clk);
        model = n[31:0]; model_irq = n[32];
        wr_en = 0; done_i = '0;
        chk({req, " word"}, rd_data, model);
        chk({req, " irq"}, {31'd0, irq_o}, {31'd0, model_irq});
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 reset word", rd_data, 32'h0);
        chk("R1 reset irq", {31'd0, irq_o}, 32'h0);
        // R2: bit 31 written alone stays zero
        cyc("R2", 1, 32'h8000_0000, 0);
        chk("R2 bit31", {31'd0, rd_data[31]}, 32'h0);
        // R9: low bits do not raise the aggregate
        cyc("R9", 1, 32'h00FF_7FFF, 0);
        chk("R9 bit31", {31'd0, rd_data[31]}, 32'h0);
        // R5: enabled channels 0 and 3 set, disabled not
        cyc("R4", 1, 32'h0009_0000, 0);
        cyc("R5", 0, 0, 7'h7F);
        chk("R5 flags", {25'd0, rd_data[30:24]}, 32'h09);
        // R7/R8: master enable raises level and pulses once
        cyc("R8", 1, 32'h0089_0000, 0);
        chk("R8 irq rise", {31'd0, irq_o}, 32'h1);
        cyc("R8 hold", 0, 0, 0);
        chk("R8 no repeat", {31'd0, irq_o}, 32'h0);
        // R3: clear channel 0 only, writing 0 leaves channel 3
        cyc("R3", 1, 32'h0189_0000, 0);
        chk("R3 partial", {25'd0, rd_data[30:24]}, 32'h08);
        // R6: set wins over clear on channel 3
        cyc("R6", 1, 32'h0889_0000, 7'h08);
        chk("R6 set wins", {25'd0, rd_data[30:24]}, 32'h08);
        // R8: drop and re-rise through force bit
        cyc("R3 clear", 1, 32'h0889_0000, 0);
        cyc("R7 force", 1, 32'h0000_8000, 0);
        chk("R7 force bit31", {31'd0, rd_data[31]}, 32'h1);
        cyc("R8 drop", 1, 32'h0, 0);
        for (int i = 0; i < 2000; i++) begin
            logic        we;
            logic [31:0] wd;
            logic [6:0]  dn;
            we = ($urandom % 4) == 0;
            wd = $urandom;
            if (($urandom % 2) == 0) wd[15] = 1'b0;
            dn = 7'($urandom) & 7'($urandom);
            cyc("R7 R8 random", we, wd, dn);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule